// File: doc/BRIEF.md
# Interleaved ROM Search Byte Engine

This block sits between the byte-wide transmit/receive datapath of a 1-Wire master and the engine that times individual bit slots on the wire. In plain byte mode it turns each transmitted byte into eight write slots, least significant bit first, and gathers the level sampled in each slot into the received byte. When the search mode input is high at the moment a byte is accepted, the byte is treated as four search directions instead. The engine then runs one search step for each of four consecutive ROM positions: read the bit, read its complement, and write the chosen bit back.

For every search position the engine picks the bit to write from the two reads. Two zeros mean a discrepancy, so the host's direction bit is used. Two different values mean every responder agrees, so the first read is written. Two ones mean nobody answered; a one is written and both result flags are set. The received byte gives the chosen bit and the discrepancy flag for each of the four positions. Sixteen such exchanges cover a whole 64-bit ROM. The host enters the mode after sending the search command byte and works out the next branch itself from the results.

Top module: `swa_top`

## Requirements
- R1: After synchronous reset, busy, rx_full, tx_sr_empty and slot_go are 0 and rx_data is 0x00.
- R2: In plain mode an accepted byte produces exactly eight slots, whose slot_wbit values are tx_data bit 0 up to bit 7 in turn. Bit i of rx_data is the slot_rbit returned for slot i.
- R3: In search mode an accepted byte produces exactly twelve slots: for each ROM position k = 0..3 in ascending order, two read slots (slot_wbit = 1) followed by one write slot. The direction for position k is tx_data bit 2k+1.
- R4: When both reads of a position return 0, the write slot drives the direction bit, the chosen bit equals the direction and the discrepancy flag is 1.
- R5: When the two reads of a position differ, the write slot drives the first read value, the chosen bit equals it and the discrepancy flag is 0.
- R6: When both reads of a position return 1, the write slot drives 1 and both the chosen bit and the discrepancy flag are 1. For the last position of the sixteenth byte this gives bits 7 and 6 both set, which marks a bus error.
- R7: In search mode rx_data bit 2k+1 holds the chosen bit and bit 2k holds the discrepancy flag of position k.
- R8: One cycle after the slot_done of a byte's last slot, rx_data is updated, rx_full and tx_sr_empty are high for exactly one cycle, and busy is low.
- R9: A tx_valid pulse while busy is high is ignored: it adds no slot and does not alter the current byte's result.
- R10: The mode is taken when a byte is accepted; changing srch_mode while busy has no effect on that byte.
- R11: At most one slot is outstanding: slot_go is a one-cycle pulse, only while busy, never while an earlier slot is still waiting for its slot_done.
- R12: A slot_done while idle is ignored: it raises no rx_full and does not change the next byte's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| srch_mode | input | 1 | Search mode select, taken when a byte is accepted |
| tx_valid | input | 1 | One-cycle pulse offering tx_data |
| tx_data | input | BYTE_W | Byte to send, or four interleaved search directions |
| busy | output | 1 | A byte exchange is in progress |
| slot_go | output | 1 | Request for one bit slot |
| slot_wbit | output | 1 | Level for the requested slot (1 also for read slots) |
| slot_done | input | 1 | The outstanding slot has completed |
| slot_rbit | input | 1 | Level sampled in the completed slot |
| rx_data | output | BYTE_W | Received byte, or interleaved chosen bits and discrepancy flags |
| rx_full | output | 1 | Pulse: rx_data holds a new byte |
| tx_sr_empty | output | 1 | Pulse: the transmitted byte has been fully shifted out |

## Verification
The bench builds the block with its default byte width of 8, so there are four search positions per byte. A behavioural slot responder answers each slot after three cycles. This latency keeps the engine waiting between slots and leaves room to inject a second tx_valid and a mode flip while a byte is in progress. The responder provides every pair of read outcomes, covering each decision branch, including the two-ones pattern in the last position that marks a bus error. It also injects a slot completion while the engine is idle.

// File: rtl/swa_pkg.sv
package swa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_st_t;

    typedef enum logic [1:0] {
        PH_BIT = 2'd0,
        PH_CMP = 2'd1,
        PH_WR  = 2'd2
    } phase_t;

    typedef struct packed {
        logic chosen;
        logic disc;
    } verdict_t;

    // Decide the branch for one ROM position from the true and complement reads.
    function automatic verdict_t judge(input logic b, input logic c, input logic dir);
        verdict_t v;
        unique case ({b, c})
            2'b00:   begin v.chosen = dir;  v.disc = 1'b1; end
            2'b01:   begin v.chosen = 1'b0; v.disc = 1'b0; end
            2'b10:   begin v.chosen = 1'b1; v.disc = 1'b0; end
            default: begin v.chosen = 1'b1; v.disc = 1'b1; end
        endcase
        return v;
    endfunction

    function automatic phase_t next_phase(input phase_t p);
        unique case (p)
            PH_BIT:  return PH_CMP;
            PH_CMP:  return PH_WR;
            default: return PH_BIT;
        endcase
    endfunction

endpackage

// File: rtl/swa_seq.sv
module swa_seq import swa_pkg::*; #(
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned IDX_W = $clog2(BYTE_W),
    localparam int unsigned POS_N = BYTE_W / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              srch_mode,
    input  logic              tx_valid,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              slot_done,
    input  logic              chosen,
    output logic              busy,
    output logic              slot_go,
    output logic              slot_wbit,
    output logic              start,
    output logic              samp_en,
    output logic              last_done,
    output logic              mode_q,
    output phase_t            ph,
    output logic [IDX_W-1:0]  idx,
    output logic              dir
);

    seq_st_t           st;
    logic [BYTE_W-1:0] data_q;
    logic              last;
    logic [IDX_W-1:0]  dir_pos;

    assign dir_pos   = {idx[IDX_W-2:0], 1'b1};
    assign dir       = data_q[dir_pos];
    assign busy      = (st != ST_IDLE);
    assign start     = (st == ST_IDLE) && tx_valid;
    assign slot_go   = (st == ST_ISSUE);
    assign samp_en   = (st == ST_WAIT) && slot_done;
    assign last      = mode_q ? ((idx == IDX_W'(POS_N - 1)) && (ph == PH_WR))
                              : (idx == IDX_W'(BYTE_W - 1));
    assign last_done = samp_en && last;

    always_comb begin
        if (!mode_q)
            slot_wbit = data_q[idx];
        else if (ph == PH_WR)
            slot_wbit = chosen;
        else
            slot_wbit = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            mode_q <= 1'b0;
            data_q <= '0;
            idx    <= '0;
            ph     <= PH_BIT;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (tx_valid) begin
                        mode_q <= srch_mode;
                        data_q <= tx_data;
                        idx    <= '0;
                        ph     <= PH_BIT;
                        st     <= ST_ISSUE;
                    end
                end
                ST_ISSUE: st <= ST_WAIT;
                ST_WAIT: begin
                    if (slot_done) begin
                        if (last) begin
                            st <= ST_IDLE;
                        end else begin
                            st <= ST_ISSUE;
                            if (!mode_q || ph == PH_WR) begin
                                idx <= IDX_W'(idx + 1'b1);
                                ph  <= PH_BIT;
                            end else begin
                                ph  <= next_phase(ph);
                            end
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/swa_dec.sv
module swa_dec import swa_pkg::*; #(
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned IDX_W = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              samp_en,
    input  logic              last_done,
    input  logic              mode_q,
    input  phase_t            ph,
    input  logic [IDX_W-1:0]  idx,
    input  logic              dir,
    input  logic              slot_rbit,
    output logic              chosen,
    output logic [BYTE_W-1:0] rx_data,
    output logic              done
);

    logic              b_q, c_q;
    logic [BYTE_W-1:0] shadow, shadow_nx;
    verdict_t          v;
    logic [IDX_W-1:0]  hi_pos, lo_pos;

    assign v      = judge(b_q, c_q, dir);
    assign chosen = v.chosen;
    assign hi_pos = {idx[IDX_W-2:0], 1'b1};
    assign lo_pos = {idx[IDX_W-2:0], 1'b0};

    always_comb begin
        shadow_nx = shadow;
        if (samp_en) begin
            if (!mode_q) begin
                shadow_nx[idx] = slot_rbit;
            end else if (ph == PH_WR) begin
                shadow_nx[hi_pos] = v.chosen;
                shadow_nx[lo_pos] = v.disc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            b_q     <= 1'b0;
            c_q     <= 1'b0;
            shadow  <= '0;
            rx_data <= '0;
            done    <= 1'b0;
        end else begin
            done <= last_done;
            if (start)
                shadow <= '0;
            else
                shadow <= shadow_nx;
            if (last_done)
                rx_data <= shadow_nx;
            if (samp_en && mode_q && ph == PH_BIT)
                b_q <= slot_rbit;
            if (samp_en && mode_q && ph == PH_CMP)
                c_q <= slot_rbit;
        end
    end

endmodule

// File: rtl/swa_top.sv
module swa_top import swa_pkg::*; #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              srch_mode,
    input  logic              tx_valid,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              busy,
    output logic              slot_go,
    output logic              slot_wbit,
    input  logic              slot_done,
    input  logic              slot_rbit,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_full,
    output logic              tx_sr_empty
);

    localparam int unsigned IDX_W = $clog2(BYTE_W);

    logic             start, samp_en, last_done, mode_q, dir, chosen, done;
    phase_t           ph;
    logic [IDX_W-1:0] idx;

    swa_seq #(.BYTE_W(BYTE_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .srch_mode (srch_mode),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .slot_done (slot_done),
        .chosen    (chosen),
        .busy      (busy),
        .slot_go   (slot_go),
        .slot_wbit (slot_wbit),
        .start     (start),
        .samp_en   (samp_en),
        .last_done (last_done),
        .mode_q    (mode_q),
        .ph        (ph),
        .idx       (idx),
        .dir       (dir)
    );

    swa_dec #(.BYTE_W(BYTE_W)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .samp_en   (samp_en),
        .last_done (last_done),
        .mode_q    (mode_q),
        .ph        (ph),
        .idx       (idx),
        .dir       (dir),
        .slot_rbit (slot_rbit),
        .chosen    (chosen),
        .rx_data   (rx_data),
        .done      (done)
    );

    assign rx_full     = done;
    assign tx_sr_empty = done;

endmodule

// File: rtl/swa_chk.sv
module swa_chk (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic slot_go,
    input logic slot_done,
    input logic rx_full
);

    logic outst;
    logic rst_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst)
            outst <= 1'b0;
        else if (slot_go)
            outst <= 1'b1;
        else if (slot_done)
            outst <= 1'b0;
    end

    // R1
    always_ff @(posedge clk) begin
        if (rst_d && !rst)
            reset_idle_chk: assert (!busy && !rx_full && !slot_go);
    end

    // R11
    single_slot_chk: assert property (@(posedge clk) disable iff (rst)
        slot_go |-> !outst);

    // R11
    go_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        slot_go |=> !slot_go);

    // R11
    go_busy_chk: assert property (@(posedge clk) disable iff (rst)
        slot_go |-> busy);

    // R8
    full_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_full |=> !rx_full);

    // R8
    full_idle_chk: assert property (@(posedge clk) disable iff (rst)
        rx_full |-> !busy);

endmodule

bind swa_top swa_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .slot_go   (slot_go),
    .slot_done (slot_done),
    .rx_full   (rx_full)
);

// File: tb/swa_top_tb.sv
module swa_top_tb;

    localparam int CLK_P = 10;
    localparam int LAT   = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       srch_mode = 1'b0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = '0;
    logic       busy, slot_go, slot_wbit, rx_full, tx_sr_empty;
    logic       slot_done, slot_rbit;
    logic [7:0] rx_data;

    int   checks = 0;
    int   errors = 0;
    bit   exp_w[$];
    bit   exp_r[$];
    bit   exp_full = 1'b0;
    bit   stray_req = 1'b0;
    string cur_tag = "R2";

    always #(CLK_P/2) clk = ~clk;

    swa_top #(.BYTE_W(8)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .srch_mode   (srch_mode),
        .tx_valid    (tx_valid),
        .tx_data     (tx_data),
        .busy        (busy),
        .slot_go     (slot_go),
        .slot_wbit   (slot_wbit),
        .slot_done   (slot_done),
        .slot_rbit   (slot_rbit),
        .rx_data     (rx_data),
        .rx_full     (rx_full),
        .tx_sr_empty (tx_sr_empty)
    );

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Behavioural bit-slot responder, compared every clock.
    initial begin
        bit pend = 0;
        bit cur_r = 0;
        int cnt = 0;
        slot_done = 1'b0;
        slot_rbit = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                chk(rx_full === exp_full, "R8 rx_full", {7'd0, rx_full}, {7'd0, exp_full});
                chk(tx_sr_empty === exp_full, "R8 tx_sr_empty", {7'd0, tx_sr_empty}, {7'd0, exp_full});
                exp_full = 1'b0;
                if (slot_done) slot_done = 1'b0;
                if (stray_req) begin
                    stray_req = 1'b0;
                    slot_done = 1'b1;
                    slot_rbit = 1'b1;
                end else if (slot_go) begin
                    if (exp_w.size() == 0) begin
                        chk(1'b0, "R9 unexpected slot", 8'd1, 8'd0);
                    end else begin
                        chk(slot_wbit === exp_w[0], {cur_tag, " slot_wbit"}, {7'd0, slot_wbit}, {7'd0, exp_w[0]});
                        cur_r = exp_r[0];
                        void'(exp_w.pop_front());
                        void'(exp_r.pop_front());
                        pend = 1;
                        cnt  = LAT;
                    end
                end else if (pend) begin
                    cnt--;
                    if (cnt == 0) begin
                        slot_done = 1'b1;
                        slot_rbit = cur_r;
                        pend = 0;
                        if (exp_w.size() == 0) exp_full = 1'b1;
                    end
                end
            end
        end
    end

    // One byte exchange; poke injects a tx_valid and a mode flip while busy.
    task automatic run_byte(input bit m, input logic [7:0] d, input logic [7:0] rsp,
                            input logic [3:0] fb, input logic [3:0] cb,
                            input string tag, input bit poke);
        logic [7:0] exp_rx;
        exp_rx = '0;
        cur_tag = tag;
        if (!m) begin
            for (int i = 0; i < 8; i++) begin
                exp_w.push_back(d[i]);
                exp_r.push_back(rsp[i]);
                exp_rx[i] = rsp[i];
            end
        end else begin
            for (int k = 0; k < 4; k++) begin
                bit w, ch, ds;
                exp_w.push_back(1'b1); exp_r.push_back(fb[k]);
                exp_w.push_back(1'b1); exp_r.push_back(cb[k]);
                if (!fb[k] && !cb[k]) begin w = d[2*k+1]; ds = 1; end
                else if (fb[k] != cb[k]) begin w = fb[k]; ds = 0; end
                else begin w = 1; ds = 1; end
                ch = w;
                exp_w.push_back(w); exp_r.push_back(w);
                exp_rx[2*k+1] = ch;
                exp_rx[2*k]   = ds;
            end
        end
        srch_mode = m;
        tx_data   = d;
        tx_valid  = 1'b1;
        @(negedge clk);
        tx_valid  = 1'b0;
        if (poke) begin
            @(negedge clk);
            chk(busy === 1'b1, "R9 busy", {7'd0, busy}, 8'd1);
            tx_valid  = 1'b1;
            tx_data   = ~d;
            srch_mode = !m;
            @(negedge clk);
            tx_valid  = 1'b0;
        end
        while (rx_full !== 1'b1) @(negedge clk);
        chk(rx_data === exp_rx, tag, rx_data, exp_rx);
        chk(busy === 1'b0, "R8 busy low", {7'd0, busy}, 8'd0);
        chk(exp_w.size() == 0, {tag, " slot count"}, 8'(exp_w.size()), 8'd0);
        srch_mode = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk(busy === 1'b0,    "R1 busy",    {7'd0, busy},    8'd0);
        chk(rx_full === 1'b0, "R1 rx_full", {7'd0, rx_full}, 8'd0);
        chk(slot_go === 1'b0, "R1 slot_go", {7'd0, slot_go}, 8'd0);
        chk(tx_sr_empty === 1'b0, "R1 tx_sr_empty", {7'd0, tx_sr_empty}, 8'd0);
        chk(rx_data === 8'h00, "R1 rx_data", rx_data, 8'h00);
        rst = 1'b0;
        @(negedge clk);

        run_byte(1'b0, 8'hA5, 8'hA5, 4'h0, 4'h0, "R2 plain echo", 1'b0);
        run_byte(1'b0, 8'hFF, 8'h3C, 4'h0, 4'h0, "R2 plain pulled", 1'b0);
        run_byte(1'b1, 8'hAA, 8'h00, 4'h0, 4'h0, "R4 R3 dir ones", 1'b0);
        run_byte(1'b1, 8'h00, 8'h00, 4'h0, 4'h0, "R4 R3 dir zeros", 1'b0);
        run_byte(1'b1, 8'h88, 8'h00, 4'b0101, 4'b1010, "R5 agree", 1'b0);
        run_byte(1'b1, 8'h00, 8'h00, 4'b1111, 4'b1111, "R6 no responder", 1'b0);
        run_byte(1'b1, 8'h22, 8'h00, 4'b1100, 4'b1000, "R6 bus error pos63", 1'b0);
        run_byte(1'b1, 8'h22, 8'h00, 4'b0010, 4'b0100, "R7 mixed", 1'b0);
        run_byte(1'b1, 8'h80, 8'h00, 4'b0000, 4'b0001, "R10 R9 search poke", 1'b1);
        run_byte(1'b0, 8'h5A, 8'hC3, 4'h0, 4'h0, "R10 R9 plain poke", 1'b1);

        // R12: stray completion while idle
        stray_req = 1'b1;
        repeat (4) @(negedge clk);
        chk(busy === 1'b0, "R12 stays idle", {7'd0, busy}, 8'd0);
        run_byte(1'b0, 8'h0F, 8'h81, 4'h0, 4'h0, "R12 next byte", 1'b0);

        repeat (20) @(negedge clk);
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

endmodule